// File: doc/BRIEF.md
# Self-Correcting Decoded Twisted-Ring Divide-by-8 Counter

This block is a four-stage twisted-ring counter that steps through eight states and presents the current state as eight one-hot decoded outputs, together with an active-low carry that is low for the upper half of the cycle. Two count inputs of opposite edge sense gate each other. One counts on its rising edge while the other is low. The other counts on its falling edge while the first is high. Either input can therefore serve as the clock and the other as a level enable.

Both count inputs are treated as asynchronous levels. They pass through a synchronizer on a fast system clock, and count events are found by comparing the current and previous synchronized samples. At most one step happens per system clock cycle. A clear input forces state 0 at once, without waiting for a clock. Its release is synchronized, so the first qualifying event after release moves the counter to state 1. The feedback term is shaped so that any of the eight unused codes falls back into the valid cycle within a few count events. A synchronous load port lets the state register be preset, so that this recovery can be exercised.

Top module: `ring8_counter`

## Requirements
- R1: While `clr` is high, `dec_o` is 8'b0000_0001 and `carry_n_o` is 1. This takes effect asynchronously, before any clock edge.
- R2: A low-to-high change of `cnt_up_i` while `cnt_dn_i` is low advances the counter by exactly one state. A high-to-low change of `cnt_up_i` does not advance it.
- R3: A low-to-high change of `cnt_up_i` while `cnt_dn_i` is high does not advance the counter.
- R4: A high-to-low change of `cnt_dn_i` while `cnt_up_i` is high advances the counter by exactly one state.
- R5: Changes of `cnt_dn_i` while `cnt_up_i` is low do not advance the counter.
- R6: In state k (0..7), only `dec_o[k]` is high. Each advance goes from state k to state (k+1) mod 8, so state 7 wraps to state 0.
- R7: `carry_n_o` is 0 in states 4 to 7 and 1 in states 0 to 3.
- R8: A high `ld_en` at a clock edge copies `ld_val` into the state register, with bit 3 as the MSB. It takes precedence over a count event. The valid codes for states 0..7 are 0000, 0001, 0011, 0111, 1111, 1110, 1100 and 1000.
- R9: Each of the eight other 4-bit codes, once loaded, shows more than one `dec_o` bit high. After at most 11 count events, exactly one bit is high, and counting then continues in the valid cycle.
- R10: Count input activity while `clr` is high is ignored. After release, the first qualifying event moves the counter to state 1.
- R11: A rising `cnt_up_i` and a falling `cnt_dn_i` that are seen in the same sampling cycle produce a single advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| clr | input | 1 | Asynchronous clear to state 0, active high |
| cnt_up_i | input | 1 | Count input, rising edge, enabled while `cnt_dn_i` is low |
| cnt_dn_i | input | 1 | Count input, falling edge, enabled while `cnt_up_i` is high |
| ld_en | input | 1 | Synchronous state-load strobe |
| ld_val | input | 4 | Code to load into the state register |
| dec_o | output | 8 | One-hot decoded state outputs, registered |
| carry_n_o | output | 1 | Active-low carry, low in states 4 to 7 |

## Verification
The bench drives each count input with the other one held both low and high. A design that ignored the gating would count on the disabled edge, and a design that inverted it would drop real events. Simultaneous edges on both inputs are also driven: a design that summed the two event terms would skip a state. Every unused code is loaded and then counted until it recovers, which exposes a feedback term that locks into a parasitic loop or takes longer than 11 events. Clear is applied between clock edges and held while the inputs toggle, which catches a synchronous-only clear and any count leaking through on release.

// File: rtl/ring8_pkg.sv
package ring8_pkg;
  parameter int unsigned JC_STAGES = 4;
  localparam int unsigned JC_STATES = 2 * JC_STAGES;
  localparam int unsigned JC_RECOVER_MAX = 11;

  typedef logic [JC_STAGES-1:0] jc_state_t;
  typedef logic [JC_STATES-1:0] jc_dec_t;

  // Next code after one count event. The shift-in bit keeps the normal
  // twisted-ring inversion for legal codes and steers unused codes home.
  function automatic jc_state_t jc_next(input jc_state_t s);
    logic fb;
    fb = ~s[JC_STAGES-1] & (s[0] | ~(|s[JC_STAGES-2:1]));
    return {s[JC_STAGES-2:0], fb};
  endfunction

  // Two-input decode of each state from adjacent stage pairs.
  function automatic jc_dec_t jc_decode(input jc_state_t s);
    jc_dec_t d;
    d = '0;
    for (int k = 0; k < int'(JC_STAGES); k++) begin
      if (k == 0) begin
        d[k] = ~s[JC_STAGES-1] & ~s[0];
        d[k+JC_STAGES] = s[JC_STAGES-1] & s[0];
      end else begin
        d[k] = s[k-1] & ~s[k];
        d[k+JC_STAGES] = ~s[k-1] & s[k];
      end
    end
    return d;
  endfunction

  function automatic logic jc_upper_half(input jc_state_t s);
    return s[JC_STAGES-1];
  endfunction
endpackage

// File: rtl/ring8_insync.sv
module ring8_insync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [DEPTH];

  generate
    for (genvar i = 0; i < int'(DEPTH); i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) pipe[i] <= d_i;
      end else begin : g_rest
        always_ff @(posedge clk) pipe[i] <= pipe[i-1];
      end
    end
  endgenerate

  assign q_o = pipe[DEPTH-1];
endmodule

// File: rtl/ring8_rstsync.sv
module ring8_rstsync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic clr,
  output logic rst_int
);
  logic [DEPTH-1:0] hold_q;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) hold_q <= '1;
    else     hold_q <= {hold_q[DEPTH-2:0], 1'b0};
  end

  assign rst_int = hold_q[DEPTH-1];
endmodule

// File: rtl/ring8_step_detect.sv
module ring8_step_detect (
  input  logic clk,
  input  logic rst_int,
  input  logic up_s,
  input  logic dn_s,
  output logic up_hit,
  output logic dn_hit,
  output logic adv
);
  logic up_p, dn_p;

  // Previous samples are left unreset so a level held across clear
  // release is not mistaken for an edge.
  always_ff @(posedge clk) begin
    up_p <= up_s;
    dn_p <= dn_s;
  end

  assign up_hit = up_s & ~up_p & ~dn_s;
  assign dn_hit = ~dn_s & dn_p & up_s;
  assign adv    = (up_hit | dn_hit) & ~rst_int;
endmodule

// File: rtl/ring8_core.sv
module ring8_core
  import ring8_pkg::*;
(
  input  logic      clk,
  input  logic      rst_int,
  input  logic      adv,
  input  logic      ld,
  input  jc_state_t ld_val,
  output jc_state_t state_q,
  output jc_dec_t   dec_q,
  output logic      carry_n_q
);
  jc_state_t state_d;

  always_comb begin
    state_d = state_q;
    if (ld)       state_d = ld_val;
    else if (adv) state_d = jc_next(state_q);
  end

  // Outputs are registered from the next-state decode, so they change on
  // the same edge as the state and carry no decode hazards.
  always_ff @(posedge clk or posedge rst_int) begin
    if (rst_int) begin
      state_q   <= '0;
      dec_q     <= jc_dec_t'(1);
      carry_n_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      dec_q     <= jc_decode(state_d);
      carry_n_q <= ~jc_upper_half(state_d);
    end
  end
endmodule

// File: rtl/ring8_counter.sv
module ring8_counter
  import ring8_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned RST_DEPTH  = 2
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 cnt_up_i,
  input  logic                 cnt_dn_i,
  input  logic                 ld_en,
  input  logic [JC_STAGES-1:0] ld_val,
  output logic [JC_STATES-1:0] dec_o,
  output logic                 carry_n_o
);
  logic      rst_int;
  logic [1:0] cnt_s;
  logic      up_hit, dn_hit, adv_evt;
  jc_state_t state_q;
  jc_dec_t   dec_q;
  logic      carry_n_q;

  ring8_rstsync #(.DEPTH(RST_DEPTH)) u_rst (
    .clk(clk), .clr(clr), .rst_int(rst_int)
  );

  ring8_insync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .d_i({cnt_dn_i, cnt_up_i}), .q_o(cnt_s)
  );

  ring8_step_detect u_step (
    .clk(clk), .rst_int(rst_int), .up_s(cnt_s[0]), .dn_s(cnt_s[1]),
    .up_hit(up_hit), .dn_hit(dn_hit), .adv(adv_evt)
  );

  ring8_core u_core (
    .clk(clk), .rst_int(rst_int), .adv(adv_evt), .ld(ld_en),
    .ld_val(ld_val), .state_q(state_q), .dec_q(dec_q), .carry_n_q(carry_n_q)
  );

  assign dec_o     = dec_q;
  assign carry_n_o = carry_n_q;
endmodule

// File: rtl/ring8_counter_chk.sv
module ring8_counter_chk
  import ring8_pkg::*;
(
  input logic            clk,
  input logic            clr,
  input logic            rst_int,
  input logic            adv,
  input logic            ld,
  input logic [JC_STATES-1:0] dec,
  input logic            carry_n
);
  logic [4:0] bad_cnt;

  always_ff @(posedge clk or posedge rst_int) begin
    if (rst_int)                  bad_cnt <= '0;
    else if (ld || $onehot(dec))  bad_cnt <= '0;
    else if (adv && bad_cnt != 5'd31) bad_cnt <= bad_cnt + 5'd1;
  end

  assert_clear_state_R1: assert property (@(posedge clk)
    clr |-> (dec == JC_STATES'(1) && carry_n));

  assert_step_rotates_R6: assert property (@(posedge clk) disable iff (rst_int)
    ($onehot(dec) && adv && !ld) |=>
      dec == {$past(dec[JC_STATES-2:0]), $past(dec[JC_STATES-1])});

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (rst_int)
    (!adv && !ld) |=> $stable(dec) && $stable(carry_n));

  assert_carry_half_R7: assert property (@(posedge clk) disable iff (rst_int)
    $onehot(dec) |-> (carry_n == |dec[JC_STAGES-1:0]));

  assert_recover_bound_R9: assert property (@(posedge clk) disable iff (rst_int)
    bad_cnt <= 5'(JC_RECOVER_MAX));
endmodule

bind ring8_counter ring8_counter_chk u_chk (
  .clk(clk), .clr(clr), .rst_int(rst_int), .adv(adv_evt),
  .ld(ld_en), .dec(dec_o), .carry_n(carry_n_o)
);

// File: tb/ring8_counter_test.sv
`timescale 1ns/1ps
module ring8_counter_test;
  logic clk = 1'b0;
  logic clr, up, dn, ld_en;
  logic [3:0] ld_val;
  logic [7:0] dec_o;
  logic carry_n_o;

  int n_total = 0;
  int n_fail  = 0;
  int mdl     = 0;

  typedef struct { logic [7:0] dec; logic carry_n; string tag; } exp_t;
  exp_t sb_q[$];
  event chk_ev;

  always #2.5 clk = ~clk;

  ring8_counter uut (
    .clk(clk), .clr(clr), .cnt_up_i(up), .cnt_dn_i(dn),
    .ld_en(ld_en), .ld_val(ld_val), .dec_o(dec_o), .carry_n_o(carry_n_o)
  );

  function automatic logic [3:0] code_of(input int i);
    if (i <= 4) return 4'((1 << i) - 1);
    return 4'hF & 4'(4'hF << (i - 4));
  endfunction

  function automatic logic legal(input logic [3:0] c);
    for (int i = 0; i < 8; i++) if (code_of(i) == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever the driver marks a sample point.
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(dec_o == e.dec && carry_n_o == e.carry_n, e.tag,
              {carry_n_o, dec_o[6:0]} ^ 8'h00 | 8'h00 ? dec_o : dec_o, e.dec);
        if (carry_n_o != e.carry_n)
          $display("FAIL %s carry actual=%b expected=%b", e.tag, carry_n_o, e.carry_n);
      end
    end
  end

  task automatic settle;
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic expect_state(input string tag);
    exp_t e;
    e.dec = 8'(1 << mdl);
    e.carry_n = (mdl < 4);
    e.tag = tag;
    sb_q.push_back(e);
    ->chk_ev;
    #0.1;
  endtask

  task automatic drive(input logic a, input logic b);
    up = a; dn = b; settle();
  endtask

  task automatic pulse_up;
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
  endtask

  task automatic load(input logic [3:0] c);
    @(posedge clk); #1;
    ld_en = 1'b1; ld_val = c;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  initial begin
    #1000000;
    n_total++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    clr = 1'b1; up = 1'b0; dn = 1'b0; ld_en = 1'b0; ld_val = '0;
    settle();
    mdl = 0; expect_state("R1 reset state");

    clr = 1'b0; settle();
    pulse_up(); mdl = 1; expect_state("R10 first event after release");
    // R2 falling of cnt_up is not an event; R6/R7 walk the full cycle with wrap
    for (int i = 0; i < 8; i++) begin
      pulse_up(); mdl = (mdl + 1) % 8;
      expect_state("R6 R7 R2 step and carry");
    end

    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1); expect_state("R3 rise up gated by dn high");
    drive(1'b1, 1'b0); mdl = (mdl + 1) % 8; expect_state("R4 fall dn with up high");

    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0); expect_state("R5 dn toggles with up low");

    drive(1'b0, 1'b1);
    drive(1'b1, 1'b0); mdl = (mdl + 1) % 8; expect_state("R11 simultaneous edges one step");
    drive(1'b0, 1'b0);

    load(code_of(3)); mdl = 3; expect_state("R8 load legal code");
    load(code_of(6)); mdl = 6; expect_state("R8 load second legal code");

    for (int c = 0; c < 16; c++) begin
      if (!legal(4'(c))) begin
        int n;
        int idx;
        load(4'(c));
        check($countones(dec_o) > 1, $sformatf("R9 illegal code %b decodes multi-hot", 4'(c)),
              dec_o, 8'hFF);
        n = 0;
        while (!$onehot(dec_o) && n < 11) begin
          pulse_up(); n++;
        end
        check($onehot(dec_o), $sformatf("R9 recovery from %b within 11", 4'(c)), dec_o, 8'h01);
        idx = 0;
        for (int k = 0; k < 8; k++) if (dec_o[k]) idx = k;
        pulse_up(); mdl = (idx + 1) % 8;
        expect_state("R9 counting resumes after recovery");
      end
    end

    pulse_up(); pulse_up();
    @(posedge clk); #1;
    clr = 1'b1; #1;
    mdl = 0;
    check(dec_o == 8'h01 && carry_n_o == 1'b1, "R1 clear takes effect before clock edge",
          dec_o, 8'h01);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0); expect_state("R10 events ignored under clear");
    clr = 1'b0; settle();
    drive(1'b0, 1'b0); expect_state("R10 held input level not counted at release");
    pulse_up(); mdl = 1; expect_state("R10 first event after release");

    settle();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule